// File: doc/BRIEF.md
# Credit-Flow Wormhole Link

This block joins a flit source to a flit sink across one router-to-router hop. The path has a registered link stage, a receive buffer of `DEPTH` entries and a credit return path. Packets travel as worms of flits. The first flit (head) carries the routing information. Body flits follow it and a tail flit closes the packet. A packet of one flit uses a single kind that is both head and tail. The link never interleaves flits of two packets, and it never reorders flits.

The sending half holds a counter of the free slots in the receive buffer. It starts at `DEPTH` after reset. The sender takes a flit from its input only while that counter is nonzero, and each flit it takes uses one credit. When a flit leaves the receive buffer, one credit pulse starts back along the return path. That path is a chain of `DELAY` registers, which model the wire and pipeline round trip. While the counter is zero, the head of the waiting worm stays at the sender input, and every flit behind it stays there too.

The receiving half runs a framing state machine on the link with two states:
- `WS_GAP` means the link is between packets.
  - A head flit moves it to `WS_WORM` (transition *open*).
  - A single-flit packet leaves it in `WS_GAP` (transition *solo*).
- `WS_WORM` means a packet is in progress.
  - A body flit keeps it in `WS_WORM` (transition *extend*).
  - A tail flit returns it to `WS_GAP` (transition *close*).

Top module: `wh_link`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, `link_valid` is 0 and `link_credit` is 0. The credit counter equals `DEPTH`.
- R2: A flit is `{kind[1:0], payload}`, with kind in the two most significant bits: 00 body, 01 head, 10 tail, 11 single-flit packet. Flits leave `out_flit` unchanged and in the order they were accepted. On the link, a body or tail flit only follows an open head, and a head or single-flit packet only arrives between packets.
- R3: While the counter is zero the sender accepts nothing. With no flit drained, at most `DEPTH` flits are accepted. Buffer occupancy, plus credits held, plus flits on the link, plus credits in the return path, always equals `DEPTH`.
- R4: Each flit drained from the buffer produces exactly one `link_credit` pulse, `DELAY` cycles after the drain edge.
- R5: `in_ready` rises one cycle after the credit pulse, which is `DELAY+1` cycles after the drain. The counter never exceeds `DEPTH`.
- R6: A credit that arrives in the same cycle as an accepted flit leaves the counter unchanged. After long streaming followed by a full drain, exactly `DEPTH` flits are accepted again.
- R7: An accepted flit is on the link (`link_valid`) in the next cycle. When the buffer was empty, it appears on `out_valid` in the cycle after that.
- R8: While `out_ready` is low, `out_valid` stays high and `out_flit` is held. No flit is lost or duplicated across a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source offers a flit |
| in_ready | output | 1 | Sender holds a credit and takes the flit |
| in_flit | input | DATA_W+2 | Offered flit, kind in the top two bits |
| link_valid | output | 1 | Flit present on the link stage |
| link_flit | output | DATA_W+2 | Flit on the link stage |
| link_credit | output | 1 | Credit pulse arriving back at the sender |
| out_valid | output | 1 | Receive buffer has a flit |
| out_ready | input | 1 | Sink takes the head of the buffer |
| out_flit | output | DATA_W+2 | Oldest buffered flit |

## Verification
Several properties are checked on every cycle:
- slot conservation across the buffer, the counter, the link stage and the return path;
- no transmission in a cycle after the counter reads zero;
- a stable counter when a send and a return meet;
- held output during a stall;
- the link framing against the `WS_GAP`/`WS_WORM` state.

The bench scenarios show the things a single-cycle property cannot:
- the exact `DELAY`-cycle credit turnaround;
- in-order delivery of whole packets;
- the count of `DEPTH` accepted flits before a stall;
- the recovery of the full credit count after long streaming.

// File: rtl/wh_link_pkg.sv
package wh_link_pkg;
    localparam int KIND_W = 2;

    typedef enum logic [1:0] {
        FK_BODY = 2'b00,
        FK_HEAD = 2'b01,
        FK_TAIL = 2'b10,
        FK_SOLO = 2'b11
    } flit_kind_e;

    typedef enum logic {
        WS_GAP  = 1'b0,
        WS_WORM = 1'b1
    } worm_state_e;
endpackage

// File: rtl/wh_credit_tx.sv
module wh_credit_tx #(
    parameter int FW    = 10,
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [FW-1:0] in_flit,
    input  logic          credit_in,
    output logic          link_valid,
    output logic [FW-1:0] link_flit,
    output logic [CW-1:0] credits
);
    logic take;

    assign in_ready = (credits != '0);
    assign take     = in_valid && in_ready;

    // credit counter: +1 per returned credit, -1 per sent flit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            credits <= CW'(DEPTH);
        end else begin
            credits <= credits + CW'(credit_in) - CW'(take);
        end
    end

    // link register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_valid <= 1'b0;
            link_flit  <= '0;
        end else begin
            link_valid <= take;
            if (take) begin
                link_flit <= in_flit;
            end
        end
    end
endmodule

// File: rtl/wh_credit_pipe.sv
module wh_credit_pipe #(
    parameter int DELAY = 2,
    localparam int PW   = (DELAY > 0) ? DELAY : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          d,
    output logic          q,
    output logic [PW-1:0] stages
);
    generate
        if (DELAY == 0) begin : g_wire
            assign q      = d;
            assign stages = '0;
        end else begin : g_regs
            logic [PW-1:0] stg;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg <= '0;
                end else begin
                    stg[0] <= d;
                    for (int i = 1; i < DELAY; i++) begin
                        stg[i] <= stg[i-1];
                    end
                end
            end
            assign q      = stg[DELAY-1];
            assign stages = stg;
        end
    endgenerate
endmodule

// File: rtl/wh_rx_buffer.sv
module wh_rx_buffer
    import wh_link_pkg::*;
#(
    parameter int FW    = 10,
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          link_valid,
    input  logic [FW-1:0] link_flit,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [FW-1:0] out_flit,
    output logic          credit_ret,
    output logic [CW-1:0] occ,
    output logic          worm_open
);
    logic [FW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          pop;
    worm_state_e   state_q, state_d;
    flit_kind_e    kind;

    assign out_valid  = (occ != '0);
    assign out_flit   = mem[rd_ptr];
    assign pop        = out_valid && out_ready;
    assign credit_ret = pop;
    assign kind       = flit_kind_e'(link_flit[FW-1 -: KIND_W]);

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (link_valid) begin
                mem[wr_ptr] <= link_flit;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            occ <= occ + CW'(link_valid) - CW'(pop);
        end
    end

    // framing state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WS_GAP;
        end else begin
            state_q <= state_d;
        end
    end

    // framing next state
    always_comb begin
        state_d = state_q;
        if (link_valid) begin
            unique case (state_q)
                WS_GAP:  if (kind == FK_HEAD) state_d = WS_WORM;
                WS_WORM: if (kind == FK_TAIL) state_d = WS_GAP;
                default: state_d = WS_GAP;
            endcase
        end
    end

    assign worm_open = (state_q == WS_WORM);
endmodule

// File: rtl/wh_link.sv
module wh_link
    import wh_link_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    parameter int DELAY  = 2,
    localparam int FW    = DATA_W + KIND_W,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int PW    = (DELAY > 0) ? DELAY : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [FW-1:0] in_flit,
    output logic          link_valid,
    output logic [FW-1:0] link_flit,
    output logic          link_credit,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [FW-1:0] out_flit
);
    logic [CW-1:0] tx_credits;
    logic [CW-1:0] rx_occ;
    logic [PW-1:0] crd_stages;
    logic          crd_raw;
    logic          worm_open;

    wh_credit_tx #(.FW(FW), .DEPTH(DEPTH)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
        .credit_in(link_credit),
        .link_valid(link_valid), .link_flit(link_flit),
        .credits(tx_credits)
    );

    wh_rx_buffer #(.FW(FW), .DEPTH(DEPTH)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .link_valid(link_valid), .link_flit(link_flit),
        .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit),
        .credit_ret(crd_raw), .occ(rx_occ), .worm_open(worm_open)
    );

    wh_credit_pipe #(.DELAY(DELAY)) u_pipe (
        .clk(clk), .rst_n(rst_n),
        .d(crd_raw), .q(link_credit), .stages(crd_stages)
    );
endmodule

// File: rtl/wh_link_chk.sv
module wh_link_chk #(
    parameter int FW    = 10,
    parameter int DEPTH = 4,
    parameter int PW    = 2,
    parameter int CW    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          link_valid,
    input logic [1:0]    link_kind,
    input logic          link_credit,
    input logic          out_valid,
    input logic          out_ready,
    input logic [FW-1:0] out_flit,
    input logic [CW-1:0] credits,
    input logic [CW-1:0] occ,
    input logic [PW-1:0] stages,
    input logic          worm_open
);
    p_conserve_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ) + int'(credits) + int'(link_valid) + $countones(stages) == DEPTH);

    p_no_send_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (credits == '0) |=> !link_valid);

    p_credit_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(credits) <= DEPTH);

    p_same_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (link_credit && in_valid && in_ready) |=> $stable(credits));

    p_link_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> link_valid);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_flit)));

    p_framing_body_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (link_valid && worm_open) |-> (link_kind == 2'b00 || link_kind == 2'b10));

    p_framing_head_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (link_valid && !worm_open) |-> (link_kind == 2'b01 || link_kind == 2'b11));
endmodule

bind wh_link wh_link_chk #(.FW(FW), .DEPTH(DEPTH), .PW(PW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .link_valid(link_valid), .link_kind(link_flit[FW-1 -: 2]),
    .link_credit(link_credit),
    .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit),
    .credits(tx_credits), .occ(rx_occ), .stages(crd_stages),
    .worm_open(worm_open)
);

// File: tb/wh_link_test.sv
`timescale 1ns/100ps
module wh_link_test;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 4;
    localparam int DELAY  = 2;
    localparam int FW     = DATA_W + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          out_ready = 1'b0;
    logic [FW-1:0] in_flit = '0;
    logic          in_ready, link_valid, link_credit, out_valid;
    logic [FW-1:0] link_flit, out_flit;

    int checks = 0;
    int errors = 0;
    logic [FW-1:0] sent [256];
    logic [FW-1:0] got  [256];
    int sent_n = 0;
    int got_n  = 0;

    always #2.5 clk = ~clk;

    wh_link #(.DATA_W(DATA_W), .DEPTH(DEPTH), .DELAY(DELAY)) uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
        .link_valid(link_valid), .link_flit(link_flit), .link_credit(link_credit),
        .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit)
    );

    // handshake log, sampled 1 ns after the falling edge
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (in_valid && in_ready && sent_n < 256) begin
                sent[sent_n] = in_flit;
                sent_n++;
            end
            if (out_valid && out_ready && got_n < 256) begin
                got[got_n] = out_flit;
                got_n++;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // kind codes: 00 body, 01 head, 10 tail, 11 single
    function automatic logic [FW-1:0] mk(input int i, input int n, input logic [7:0] base);
        logic [1:0] k;
        if (n == 1)          k = 2'b11;
        else if (i == 0)     k = 2'b01;
        else if (i == n - 1) k = 2'b10;
        else                 k = 2'b00;
        return {k, base + 8'(i)};
    endfunction

    task automatic clear_log();
        @(negedge clk);
        sent_n = 0;
        got_n  = 0;
    endtask

    task automatic stream(input int n, input logic [7:0] base);
        int i = 0;
        while (i < n) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_flit  = mk(i, n, base);
            #1;
            if (in_ready) i++;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic compare_log(input string tag);
        repeat (16) @(negedge clk);
        chk({tag, " count"}, got_n, sent_n);
        for (int i = 0; i < sent_n && i < got_n; i++) begin
            chk({tag, " order"}, int'(got[i]), int'(sent[i]));
        end
    endtask

    // offer 2-flit packets for n cycles with sink stalled; return accepted count
    task automatic offer_pairs(input int cycles, input logic [7:0] base, output int acc);
        int i = 0;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_flit  = mk(i % 2, 2, base + 8'(i));
            #1;
            if (in_ready) i++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        acc = i;
    endtask

    task automatic t_reset();
        #1;
        chk("R1 in_ready", int'(in_ready), 1);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 link_valid", int'(link_valid), 0);
        chk("R1 link_credit", int'(link_credit), 0);
    endtask

    task automatic t_latency();
        clear_log();
        out_ready = 1'b0;
        in_valid  = 1'b1;
        in_flit   = mk(0, 1, 8'h5A);
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk("R7 link_valid next", int'(link_valid), 1);
        chk("R7 out_valid not yet", int'(out_valid), 0);
        @(negedge clk);
        #1;
        chk("R7 out_valid after", int'(out_valid), 1);
        chk("R7 out_flit", int'(out_flit), int'(mk(0, 1, 8'h5A)));
        out_ready = 1'b1;
        compare_log("R7");
    endtask

    task automatic t_packet();
        clear_log();
        out_ready = 1'b1;
        stream(3, 8'h10);
        stream(5, 8'h20);
        compare_log("R2 packets");
    endtask

    task automatic t_single();
        clear_log();
        out_ready = 1'b1;
        stream(1, 8'h31);
        stream(1, 8'h32);
        compare_log("R2 single");
        chk("R2 single kind", int'(got[0][FW-1 -: 2]), 3);
    endtask

    task automatic t_fill_and_turnaround();
        int acc;
        clear_log();
        out_ready = 1'b0;
        offer_pairs(10, 8'h60, acc);
        chk("R3 accepted before stall", acc, DEPTH);
        #1;
        chk("R3 in_ready at zero credit", int'(in_ready), 0);
        chk("R3 link idle at zero credit", int'(link_valid), 0);
        chk("R8 out_valid held", int'(out_valid), 1);
        chk("R8 out_flit held", int'(out_flit), int'(sent[0]));
        chk("R4 no credit while stalled", int'(link_credit), 0);
        // drain exactly one flit
        @(negedge clk);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        for (int k = 1; k <= DELAY + 1; k++) begin
            #1;
            chk("R4 credit pulse timing", int'(link_credit), (k == DELAY) ? 1 : 0);
            chk("R5 in_ready timing", int'(in_ready), (k == DELAY + 1) ? 1 : 0);
            @(negedge clk);
        end
        out_ready = 1'b1;
        compare_log("R8 drain");
    endtask

    task automatic t_stream_refill();
        int acc;
        clear_log();
        out_ready = 1'b1;
        stream(24, 8'h80);
        stream(2, 8'hC0);
        compare_log("R6 stream");
        clear_log();
        out_ready = 1'b0;
        offer_pairs(10, 8'hD0, acc);
        chk("R6 credits restored", acc, DEPTH);
        out_ready = 1'b1;
        compare_log("R6 refill");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_latency();
        t_packet();
        t_single();
        t_fill_and_turnaround();
        t_stream_refill();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule